// File: doc/BRIEF.md
# Multiplexed Address/Data Bus Controller

This block runs bus cycles on an external memory interface where the low sixteen address bits share pins with the data bus. An internal core requests a cycle with a 24-bit address, a read/write flag, an 8- or 16-bit width select and write data. The controller then runs a fixed sequence:

- **Address phase**, one clock: the address is placed on the shared lines and the latch strobe pulses.
- **Data phase**, `DATA_CYCLES` clocks (default two): the read or write strobe is active.

The block pulses `done_o` in the last data clock. Read data is registered on the edge that closes the data phase.

Only the low twenty address bits reach the pins. Bits 19:16 sit on dedicated lines for the whole cycle, and bits 23:20 are dropped. So a fetch from FF2080h appears externally as F2080h.

Two address qualifiers are produced:
- a one-clock active-high latch pulse at the start of the cycle, which an external latch uses to split the address from the data;
- an active-low valid strobe that stays low from the address phase through the last data clock, which a decoder can use for selects.

Between cycles the controller drives nothing and raises a select output, so that general-purpose port logic owns the pins.

Top module: `mux_bus_ctrl`

## Requirements
- R1: After reset, with no request, `ale_o`=0, `adv_no`=1, `rd_no`=1, `wr_no`=1, `ad_oe_o`=0, `ext_addr_o`=0, `port_sel_o`=1, `busy_o`=0, `done_o`=0 and `rdata_o`=0.
- R2: `ext_addr_o` equals request address bits 19:16 in every clock from the address phase through the last data clock, and stays stable across that span.
- R3: A request seen in idle at a rising edge starts the address phase on that edge. The address phase lasts one clock, with `ale_o`=1, `ad_o`=address bits 15:0 and `ad_oe_o`=all ones. `ale_o` is 0 in every data clock.
- R4: `adv_no` is 0 in the address phase and every data clock, and returns to 1 in the clock after the last data clock.
- R5: Address bits 23:20 have no effect on any pin. Requests at FF2080h and 0F2080h drive identical pin values: extended lines F, shared lines 2080h.
- R6: While idle, `port_sel_o`=1, `ad_oe_o`=0 and `ext_addr_o`=0. During any cycle, `port_sel_o`=0.
- R7: A write holds `wr_no`=0 and `rd_no`=1 for two data clocks. With wide=1, `ad_o`=wdata and `ad_oe_o`=FFFFh. With wide=0, `ad_o`={8'h00, wdata[7:0]} and `ad_oe_o`=00FFh.
- R8: A read holds `rd_no`=0, `wr_no`=1 and `ad_oe_o`=0 for two data clocks. From the clock after the last data clock, `rdata_o` equals the `ad_i` value at that closing edge (wide=1), or {8'h00, ad_i[7:0]} (wide=0).
- R9: `busy_o`=1 from the address phase through the last data clock. `done_o`=1 only in the last data clock.
- R10: A request, or an address change, presented while busy is ignored. No new `ale_o` pulse appears and `ext_addr_o` does not change until the controller is idle again. A request held into idle is then accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Cycle request, sampled only while idle |
| addr_i | input | 24 | Internal byte address |
| wide_i | input | 1 | 1 = 16-bit access, 0 = 8-bit access |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | 16 | Write data |
| busy_o | output | 1 | A cycle is in progress |
| done_o | output | 1 | Pulse in the last data clock |
| rdata_o | output | 16 | Read data, registered at the end of the data phase |
| ext_addr_o | output | 4 | Address bits 19:16 |
| ad_o | output | 16 | Shared address/data lines, output value |
| ad_oe_o | output | 16 | Per-line output enable for the shared lines |
| ad_i | input | 16 | Shared address/data lines, input value |
| ale_o | output | 1 | Address latch strobe, active high |
| adv_no | output | 1 | Address valid, active low |
| rd_no | output | 1 | Read strobe, active low |
| wr_no | output | 1 | Write strobe, active low |
| port_sel_o | output | 1 | 1 = port logic owns the pins |

## Verification
A wrong sequencer state shows within one clock:
- an extra or missing latch pulse;
- a valid strobe that rises early or late relative to `done_o`;
- a strobe active outside the data phase.

A corrupted captured request shows as wrong extended address or shared-line values in the address phase itself. A stale width or direction flag shows as a wrong output-enable mask in the first data clock. A faulty read capture shows only in the clock after `done_o`, so every read is checked there in the following idle clock.

// File: rtl/mbc_pkg.sv
package mbc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_DATA = 2'd2
  } bus_st_e;
endpackage

// File: rtl/mbc_seq.sv
module mbc_seq
  import mbc_pkg::*;
#(
  parameter int DATA_CYCLES = 2
) (
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    req_i,
  output bus_st_e st_o,
  output logic    accept_o,
  output logic    done_o,
  output logic    busy_o
);
  localparam int CNT_W = (DATA_CYCLES > 1) ? $clog2(DATA_CYCLES) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_CYCLES - 1);

  bus_st_e        st_q, st_d;
  logic [CNT_W-1:0] cnt_q;

  assign accept_o = (st_q == ST_IDLE) && req_i;
  assign done_o   = (st_q == ST_DATA) && (cnt_q == LAST);
  assign busy_o   = (st_q != ST_IDLE);
  assign st_o     = st_q;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_i) st_d = ST_ADDR;
      ST_ADDR: st_d = ST_DATA;
      ST_DATA: if (cnt_q == LAST) st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_DATA) cnt_q <= cnt_q + 1'b1;
      else                 cnt_q <= '0;
    end
  end

  p_done_in_cycle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> busy_o);
  p_done_to_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o);
  p_accept_only_idle_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (busy_o && !accept_o));
endmodule

// File: rtl/mbc_addr_path.sv
module mbc_addr_path #(
  parameter int EXT_W = 20,
  parameter int AD_W  = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             accept_i,
  input  logic [EXT_W-1:0] addr_i,
  output logic [AD_W-1:0]  lo_o,
  output logic [EXT_W-AD_W-1:0] hi_o
);
  logic [EXT_W-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       addr_q <= '0;
    else if (accept_i) addr_q <= addr_i;
  end

  assign lo_o = addr_q[AD_W-1:0];
  assign hi_o = addr_q[EXT_W-1:AD_W];
endmodule

// File: rtl/mbc_data_path.sv
module mbc_data_path #(
  parameter int AD_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            accept_i,
  input  logic            done_i,
  input  logic            wide_i,
  input  logic            we_i,
  input  logic [AD_W-1:0] wdata_i,
  input  logic [AD_W-1:0] ad_i,
  output logic            we_o,
  output logic [AD_W-1:0] wr_data_o,
  output logic [AD_W-1:0] wr_oe_o,
  output logic [AD_W-1:0] rdata_o
);
  localparam int LANES = AD_W / 8;

  logic            wide_q, we_q;
  logic [AD_W-1:0] wdata_q, rdata_q;
  logic [AD_W-1:0] rd_view;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wide_q  <= 1'b0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else if (accept_i) begin
      wide_q  <= wide_i;
      we_q    <= we_i;
      wdata_q <= wdata_i;
    end
  end

  // lane 0 always active; upper lanes only for wide access
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic lane_on;
    assign lane_on = (l == 0) || wide_q;
    assign wr_oe_o  [l*8 +: 8] = {8{lane_on}};
    assign wr_data_o[l*8 +: 8] = lane_on ? wdata_q[l*8 +: 8] : 8'h00;
    assign rd_view  [l*8 +: 8] = lane_on ? ad_i[l*8 +: 8]    : 8'h00;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              rdata_q <= '0;
    else if (done_i && !we_q) rdata_q <= rd_view;
  end

  assign we_o    = we_q;
  assign rdata_o = rdata_q;

  p_rdata_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(rdata_o));
endmodule

// File: rtl/mux_bus_ctrl.sv
module mux_bus_ctrl
  import mbc_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int EXT_W       = 20,
  parameter int AD_W        = 16,
  parameter int DATA_CYCLES = 2
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  req_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wide_i,
  input  logic                  we_i,
  input  logic [AD_W-1:0]       wdata_i,
  output logic                  busy_o,
  output logic                  done_o,
  output logic [AD_W-1:0]       rdata_o,
  output logic [EXT_W-AD_W-1:0] ext_addr_o,
  output logic [AD_W-1:0]       ad_o,
  output logic [AD_W-1:0]       ad_oe_o,
  input  logic [AD_W-1:0]       ad_i,
  output logic                  ale_o,
  output logic                  adv_no,
  output logic                  rd_no,
  output logic                  wr_no,
  output logic                  port_sel_o
);
  localparam int HI_W = EXT_W - AD_W;

  bus_st_e          st;
  logic             accept, we_q;
  logic [AD_W-1:0]  addr_lo, wr_data, wr_oe;
  logic [HI_W-1:0]  addr_hi;
  logic             unused_hi_addr;

  assign unused_hi_addr = ^addr_i[ADDR_W-1:EXT_W];

  mbc_seq #(.DATA_CYCLES(DATA_CYCLES)) u_seq (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req_i),
    .st_o     (st),
    .accept_o (accept),
    .done_o   (done_o),
    .busy_o   (busy_o)
  );

  mbc_addr_path #(.EXT_W(EXT_W), .AD_W(AD_W)) u_addr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .accept_i (accept),
    .addr_i   (addr_i[EXT_W-1:0]),
    .lo_o     (addr_lo),
    .hi_o     (addr_hi)
  );

  mbc_data_path #(.AD_W(AD_W)) u_data (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .accept_i  (accept),
    .done_i    (done_o),
    .wide_i    (wide_i),
    .we_i      (we_i),
    .wdata_i   (wdata_i),
    .ad_i      (ad_i),
    .we_o      (we_q),
    .wr_data_o (wr_data),
    .wr_oe_o   (wr_oe),
    .rdata_o   (rdata_o)
  );

  always_comb begin
    ad_o       = '0;
    ad_oe_o    = '0;
    ale_o      = 1'b0;
    rd_no      = 1'b1;
    wr_no      = 1'b1;
    unique case (st)
      ST_ADDR: begin
        ale_o   = 1'b1;
        ad_o    = addr_lo;
        ad_oe_o = '1;
      end
      ST_DATA: begin
        if (we_q) begin
          wr_no   = 1'b0;
          ad_o    = wr_data;
          ad_oe_o = wr_oe;
        end else begin
          rd_no   = 1'b0;
        end
      end
      default: ;
    endcase
  end

  assign adv_no     = !busy_o;
  assign port_sel_o = !busy_o;
  assign ext_addr_o = busy_o ? addr_hi : '0;

  p_adv_held_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_no && !done_o) |=> !adv_no);
  p_adv_release_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> adv_no);
  p_ext_stable_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_no && !done_o) |=> $stable(ext_addr_o));
  p_ale_pulse_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ale_o |=> (!ale_o && !adv_no));
  p_idle_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    port_sel_o |-> (ad_oe_o == '0 && adv_no && rd_no && wr_no));
  p_read_float_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_no |-> (ad_oe_o == '0 && wr_no));
  p_no_restart_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !done_o) |=> !ale_o);
endmodule

// File: tb/sim_mux_bus_ctrl.sv
module sim_mux_bus_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req = 1'b0, wide = 1'b0, we = 1'b0;
  logic [23:0] addr = '0;
  logic [15:0] wdata = '0, ad_in = '0;
  logic        busy, done, ale, adv_n, rd_n, wr_n, psel;
  logic [15:0] rdata, ad_out, ad_oe;
  logic [3:0]  ext;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mux_bus_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .addr_i(addr), .wide_i(wide),
    .we_i(we), .wdata_i(wdata), .busy_o(busy), .done_o(done), .rdata_o(rdata),
    .ext_addr_o(ext), .ad_o(ad_out), .ad_oe_o(ad_oe), .ad_i(ad_in),
    .ale_o(ale), .adv_no(adv_n), .rd_no(rd_n), .wr_no(wr_n), .port_sel_o(psel)
  );

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", rq, act, exp);
    end
  endtask

  task automatic check_idle(input string rq);
    chk({rq, " ale"}, ale, 0);
    chk({rq, " adv"}, adv_n, 1);
    chk({rq, " rd"}, rd_n, 1);
    chk({rq, " wr"}, wr_n, 1);
    chk({rq, " oe"}, ad_oe, 0);
    chk({rq, " ext"}, ext, 0);
    chk({rq, " psel"}, psel, 1);
    chk({rq, " busy"}, busy, 0);
    chk({rq, " done"}, done, 0);
  endtask

  // runs one cycle; starts and ends at a negedge with the controller idle
  task automatic run_cycle(input logic [23:0] a, input logic w, input logic wr,
                           input logic [15:0] wd, input logic hold);
    logic [15:0] pat, exp_oe, exp_ad, exp_rd;
    pat    = a[15:0] ^ 16'hA5C3 ^ {wd[7:0], wd[15:8]};
    exp_oe = wr ? (w ? 16'hFFFF : 16'h00FF) : 16'h0000;
    exp_ad = w ? wd : {8'h00, wd[7:0]};
    exp_rd = w ? pat : {8'h00, pat[7:0]};
    req = 1'b1; addr = a; wide = w; we = wr; wdata = wd; ad_in = pat;
    @(negedge clk);
    chk("R3 ale addr", ale, 1);
    chk("R3 ad addr", ad_out, a[15:0]);
    chk("R3 oe addr", ad_oe, 16'hFFFF);
    chk("R4 adv addr", adv_n, 0);
    chk(a[23:20] != 0 ? "R5 ext" : "R2 ext", ext, a[19:16]);
    chk("R6 psel busy", psel, 0);
    chk("R9 busy", busy, 1);
    chk("R9 done early", done, 0);
    if (hold) begin
      addr = ~a; wide = ~w; we = ~wr; wdata = ~wd;
    end else req = 1'b0;
    for (int k = 0; k < 2; k++) begin
      @(negedge clk);
      chk(hold ? "R10 ale" : "R3 ale data", ale, 0);
      chk(hold ? "R10 ext" : "R2 ext data", ext, a[19:16]);
      chk("R4 adv data", adv_n, 0);
      chk("R9 done", done, k == 1);
      chk("R9 busy data", busy, 1);
      chk(wr ? "R7 wr" : "R8 wr", wr_n, !wr);
      chk(wr ? "R7 rd" : "R8 rd", rd_n, wr);
      chk(wr ? "R7 oe" : "R8 oe", ad_oe, exp_oe);
      if (wr) chk("R7 ad", ad_out, exp_ad);
    end
    req = 1'b0;
    @(negedge clk);
    check_idle("R6 R4 after");
    if (!wr) chk("R8 rdata", rdata, exp_rd);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_idle("R1");
    chk("R1 rdata", rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_idle("R1 post");
    for (int i = 0; i < 16; i++)
      for (int m = 0; m < 4; m++)
        run_cycle({4'(15 - i), 4'(i), 16'(16'h2080 + i * 16'h1357 + m)},
                  m[0], m[1], 16'(16'h9E37 * (i + 1) + m * 16'h0101), 1'b0);
    // R5: upper nibble dropped, same pins
    run_cycle(24'hFF2080, 1'b1, 1'b0, 16'h1234, 1'b0);
    run_cycle(24'h0F2080, 1'b1, 1'b0, 16'h1234, 1'b0);
    // R10: request and address change during busy are ignored
    run_cycle(24'h3A55AA, 1'b0, 1'b1, 16'hBEEF, 1'b1);
    run_cycle(24'h17F00F, 1'b1, 1'b0, 16'h0F0F, 1'b1);
    run_cycle(24'h200001, 1'b1, 1'b1, 16'hCAFE, 1'b0);
    repeat (2) @(negedge clk);
    check_idle("R6 final");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      tests++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule